// File: doc/BRIEF.md
# Guard-Bit Fixed-Point Sum-of-Products Unit

This unit evaluates a sum of N products, each a fixed coefficient times a signed input word. The result is delivered in a chosen final fixed-point format. Each product is brought onto one shared intermediate LSB that lies `DELTA` guard bits below the final LSB. A product finer than that LSB is shifted right, and a coarser one is shifted left with zeros filling in. The aligned terms go into an accumulator that only spans from the intermediate LSB up to the final MSB. Anything that overflows above the final MSB is dropped on purpose. The two's-complement sum is still exact modulo that range, so the result is right whenever the true value fits the final format.

The coefficients, the per-product alignment shifts, `DELTA` and the rounding mode are all elaboration parameters. A designer sets `DELTA` to the ceiling of log2 of the number of products that lose bits below the final LSB, and the result is then a faithful rounding of the exact sum. The unit latches the input words on an accepted start. It then adds one term per clock and raises a one-cycle done pulse, with the result, N+1 cycles after the start edge.

Top module: `bitfmt_sop`

## Requirements
- R1: While reset is asserted and after its release, `done_o` and `busy_o` are 0 and `result_o` is all zeros.
- R2: A start accepted at clock edge E0 produces `done_o` high for exactly one cycle, following edge E0+N+1, and not before.
- R3: A `start_i` pulse while `busy_o` is high is ignored: it neither restarts the sum nor changes the result or the done timing, and it produces no extra done pulse.
- R4: With `NEAREST`=0 (truncation), each shifted term and the final shift by `DELTA` are arithmetic right shifts. The result minus the exact sum, taken modulo 2^WF final LSBs, lies in the range (−2, 0] final LSBs.
- R5: With `NEAREST`=1, half an LSB of the target position is added before every right shift. The result differs from the exact sum, taken modulo 2^WF final LSBs, by strictly less than one final LSB.
- R6: Overflow above the final MSB wraps. Take an 8-bit final word with 3 fraction bits, `DELTA`=0, unit coefficients and no shifts. Adding 12.5 (raw 100) and 3.75 (raw 30) gives raw 8'h82, which is −15.75.
- R7: The input words are sampled only on the accepted start edge. Changes to `vars_i` while busy do not affect the result.
- R8: `result_o` changes only in the cycle in which `done_o` is high.
- R9: An accepted start drives `busy_o` high from the next cycle until the done cycle, in which `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when not busy |
| vars_i | input | N*WV | Input words, word i in bits [i*WV +: WV], signed |
| busy_o | output | 1 | Accumulation in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | WF | Signed result in the final format |

## Verification
One input word is swept over all values against all values of a second word. The remaining two words follow patterns derived from the first two. Two instances run side by side, one with truncation and one with round-to-nearest. Each run mixes a right shift of three, a right shift of one, an aligned term and a left shift, so any error in one alignment path breaks the modular error bound. Large coefficients push most sums past the final range, which tells apart correct wraparound from saturation or a wrong accumulator width. A third instance checks the exact wrap example. Runs that scramble the inputs or pulse start mid-sum separate real input latching and start gating from designs that pass only when inputs are held still.

// File: rtl/bitfmt_sop.sv
module bitfmt_sop #(
  parameter int N       = 4,
  parameter int WC      = 6,
  parameter int WV      = 6,
  parameter int WF      = 8,
  parameter int DELTA   = 2,
  parameter int NEAREST = 0,
  parameter logic [N*WC-1:0] COEFS  = {6'd32, 6'd31, 6'd47, 6'd21},
  parameter logic [N*8-1:0]  SHIFTS = {8'hFE, 8'd0, 8'd1, 8'd3}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [N*WV-1:0] vars_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [WF-1:0]   result_o
);
  localparam int WP = WC + WV;
  localparam int WA = WF + DELTA;
  localparam int WX = WA + WP + 8;
  localparam int WI = $clog2(N + 1);
  localparam logic [WA-1:0] RHALF = (NEAREST != 0) ? ((WA'(1) << DELTA) >> 1) : '0;

  logic [N*WV-1:0] vq;
  logic [WA-1:0]   acc;
  logic [WI-1:0]   cnt;
  logic [WA-1:0]   term [N];
  logic [WA-1:0]   sel;
  logic [WA-1:0]   fin;

  for (genvar i = 0; i < N; i++) begin : g_term
    localparam int SH = int'($signed(SHIFTS[i*8 +: 8]));
    logic signed [WC-1:0] c;
    logic signed [WV-1:0] v;
    logic signed [WP-1:0] p;
    logic signed [WX-1:0] px;
    assign c  = COEFS[i*WC +: WC];
    assign v  = vq[i*WV +: WV];
    assign p  = WP'(c) * WP'(v);
    assign px = {{(WX-WP){p[WP-1]}}, p};
    if (SH > 0) begin : g_rshift
      localparam logic [WX-1:0] HALF = (NEAREST != 0) ? ((WX'(1) << SH) >> 1) : '0;
      logic signed [WX-1:0] ps;
      logic signed [WX-1:0] sh;
      assign ps = px + $signed(HALF);
      assign sh = ps >>> SH;
      assign term[i] = sh[WA-1:0];
    end else begin : g_lshift
      logic signed [WX-1:0] sh;
      assign sh = px <<< (-SH);
      assign term[i] = sh[WA-1:0];
    end
  end

  assign sel = (int'(cnt) < N) ? term[cnt] : '0;
  assign fin = acc + RHALF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq       <= '0;
      acc      <= '0;
      cnt      <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          vq     <= vars_i;
          acc    <= '0;
          cnt    <= '0;
          busy_o <= 1'b1;
        end
      end else if (int'(cnt) == N) begin
        result_o <= fin[WA-1 -: WF];
        done_o   <= 1'b1;
        busy_o   <= 1'b0;
      end else begin
        acc <= acc + sel;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitfmt_sop_chk.sv
module bitfmt_sop_chk #(
  parameter int WF = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [WF-1:0] result_o
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R9
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R9
  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> (busy_o || done_o)); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R8
endmodule

bind bitfmt_sop bitfmt_sop_chk #(.WF(WF)) chk_i (.*);

// File: tb/bitfmt_sop_tb.sv
module bitfmt_sop_tb_top;
  localparam int N = 4, WC = 6, WV = 6, WF = 8, DELTA = 2, K = 8;
  localparam longint M = longint'(1) << (WF + K);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*WV-1:0] vars = '0;
  logic busy_t, done_t, busy_n, done_n, busy_w, done_w;
  logic [WF-1:0] res_t, res_n, res_w;
  int checks = 0, fails = 0;
  bit finished = 0;

  int cf [4] = '{21, -17, 31, -32};
  int sh [4] = '{3, 1, 0, -2};

  always #10 clk = ~clk;

  bitfmt_sop #(.NEAREST(0)) dut_i (.clk, .rst_n, .start_i(start), .vars_i(vars),
    .busy_o(busy_t), .done_o(done_t), .result_o(res_t));
  bitfmt_sop #(.NEAREST(1)) dut_n (.clk, .rst_n, .start_i(start), .vars_i(vars),
    .busy_o(busy_n), .done_o(done_n), .result_o(res_n));
  bitfmt_sop #(.N(2), .WC(2), .WV(8), .WF(8), .DELTA(0), .NEAREST(0),
    .COEFS(4'b0101), .SHIFTS(16'h0000)) dut_w (.clk, .rst_n, .start_i(start),
    .vars_i({8'd30, 8'd100}), .busy_o(busy_w), .done_o(done_w), .result_o(res_w));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exact(input int v [4]);
    longint s = 0;
    for (int i = 0; i < 4; i++) s += longint'(cf[i]) * v[i] * (longint'(1) << (K - DELTA - sh[i]));
    return s;
  endfunction

  function automatic longint wrapd(input longint ex, input logic [WF-1:0] r);
    longint d = ex - longint'($signed(r)) * (longint'(1) << K);
    d = ((d % M) + M) % M;
    if (d >= M / 2) d -= M;
    return d;
  endfunction

  task automatic run(input int v [4], input bit disturb, input bit restart);
    longint ex, dt, dn;
    bit early = 0;
    logic [WF-1:0] keep;
    @(negedge clk);
    vars  = {6'(v[3]), 6'(v[2]), 6'(v[1]), 6'(v[0])};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) vars = ~vars;
    for (int k = 1; k <= N + 1; k++) begin
      @(negedge clk);
      if (restart && k == 2) begin start = 1'b1; vars = ~vars; end
      if (restart && k == 3) start = 1'b0;
      if (k <= N && (done_t || done_n)) early = 1;
    end
    check(!early && done_t && done_n, "R2", longint'(done_t), 1);
    ex = exact(v);
    dt = wrapd(ex, res_t);
    dn = wrapd(ex, res_n);
    check(dt >= 0 && dt < 2 * (longint'(1) << K), disturb ? "R7" : (restart ? "R3" : "R4"),
          longint'($signed(res_t)), ex >>> K);
    check(dn > -(longint'(1) << K) && dn < (longint'(1) << K), "R5",
          longint'($signed(res_n)), ex >>> K);
    keep = res_t;
    @(negedge clk);
    check(!done_t && !busy_t, "R2", longint'(done_t), 0);
    if (restart) begin
      early = 0;
      for (int k = 0; k < N + 2; k++) begin
        @(negedge clk);
        if (done_t || busy_t) early = 1;
      end
      check(!early, "R3", longint'(early), 0);
      check(res_t == keep, "R8", longint'(res_t), longint'(keep));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done_t && !busy_t && res_t == '0, "R1", longint'(res_t), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done_t && !busy_t && res_t == '0 && res_n == '0, "R1", longint'(res_t), 0);
    @(negedge clk);
    vars  = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy_t && busy_n, "R9", longint'(busy_t), 1);
    repeat (N + 2) @(negedge clk);
    check(res_w == 8'h82, "R6", longint'(res_w), 130);
    run('{31, 31, 31, 31}, 0, 0);
    run('{-32, -32, -32, -32}, 0, 0);
    run('{5, -7, 11, -1}, 1, 0);
    run('{-19, 23, 1, 9}, 0, 1);
    run('{-3, 8, -30, 17}, 1, 1);
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++)
        run('{a - 32, b - 32, ((a * 7 + b) & 63) - 32, ((a ^ (b * 3)) & 63) - 32}, 0, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule